// File: doc/BRIEF.md
# Reader Serial Command Interface

This block is the command port of a low-frequency reader front end. A host microcontroller talks to it over three wires: a serial clock, a data line into the block and a data line out. Both incoming lines arrive already synchronised to the local system clock. The block samples them with that clock, finds the edges, and shifts in command bytes MSB first. It decodes the command set and keeps the front end's configuration state. That state is four 4-bit configuration pages, a 6-bit demodulator sampling time and a 4-bit write pulse length.

Read commands return one byte, MSB first, one bit per serial clock period. The byte is a stored register, a live 6-bit phase measurement, or a configuration page combined with either the pulse length or two status flags. Two short 3-bit commands switch the port into a streaming mode. In read streaming the received tag data is passed straight to the output line. In write streaming the host modulates the antenna through the data line. A single rising serial clock edge ends either streaming mode. Every transaction opens with a framing condition: the data line rises while the serial clock is high.

Top module: `rdr_cmd_if`

## Requirements
- R1: After reset, page 0 reads 4'b1000, pages 1 to 3 read 0, and the sampling time and pulse length are 0. Both streaming flags are low and `dout` is 1.
- R2: Bits are accepted only after a start condition, which is `din` rising while `sclk` is high. Serial clock edges outside a transaction change nothing. A new start condition in the middle of a command discards the bits already received.
- R3: Command 01PPDDDD writes DDDD into page PP. Page p appears on `cfg[4p+3:4p]`, and configuration changes only on a serial clock rising edge.
- R4: Command 10DDDDDD loads the sampling time. Command 00000010 returns {2'b00, sampling time}.
- R5: Command 00001000 returns {2'b00, phase}, with the phase captured on the eighth command bit.
- R6: Command 000001PP returns the page in bits 3..0. For pages 0 and 1, bits 7..4 hold the pulse length. For pages 2 and 3, bits 7..4 hold {0, 0, amp_cmp, ant_fail}.
- R7: Response bit 7-k is driven on `dout` from the (9+k)-th serial clock rise of the transaction, for k = 0 to 7. `dout` returns to 1 at the 17th rise. Outside responses and read streaming, `dout` holds its value.
- R8: The 3-bit prefix 111 sets `read_mode` right after the third bit. While `read_mode` is set, `dout` equals `rx_data`.
- R9: The 3-bit prefix 110 sets `write_mode` right after the third bit and leaves the pulse length unchanged.
- R10: Command 0001NNNN stores NNNN as the pulse length and sets `write_mode` after the eighth bit.
- R11: Either streaming mode ends on the next serial clock rising edge. A start condition while streaming is ignored.
- R12: Page 1 bit 2 requests power saving and bit 3 selects full power-off. `power_idle` = bit2 & !bit3 and `power_off` = bit2 & bit3.
- R13: Undefined 8-bit codes, for example 00000000 or 00000011, change no register, start no mode and produce no response (`dout` stays 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Synchronised serial clock from the host |
| din | input | 1 | Synchronised serial data from the host |
| rx_data | input | 1 | Digitised receive data for read streaming |
| phase | input | 6 | Measured antenna phase |
| amp_cmp | input | 1 | Amplitude comparison status flag |
| ant_fail | input | 1 | Antenna fault status flag |
| dout | output | 1 | Serial data to the host |
| read_mode | output | 1 | Read streaming active |
| write_mode | output | 1 | Write streaming active |
| cfg | output | 16 | Configuration pages, page p at bits 4p+3..4p |
| samp_time | output | 6 | Demodulator sampling time |
| pulse_len | output | 4 | Write pulse length |
| power_idle | output | 1 | Idle power state requested |
| power_off | output | 1 | Full power-off requested |

## Verification
A wrong bit counter or a missed start condition shows up as a wrong register value on `cfg` or `samp_time` right after the eighth bit. It can also show up as a response byte rotated by one position, seen within one read transaction. A wrong early-decode state shows up as a streaming flag that rises late or that survives the next serial clock edge, which is visible within one serial period. A stale response register shows up as `dout` not returning high after the 17th rise, or as a level change on `dout` while no transaction is running.

// File: rtl/rcif_pkg.sv
package rcif_pkg;
  localparam int CMD_W   = 8;
  localparam int SHORT_W = 3;
  localparam int PG_N    = 4;
  localparam int PG_W    = 4;
  localparam int SAMP_W  = 6;
  localparam int NLEN_W  = 4;
  localparam int PH_W    = 6;
  localparam int CNT_W   = $clog2(CMD_W);
  localparam int RCNT_W  = $clog2(CMD_W + 1);
  localparam int CFG_W   = PG_N * PG_W;

  localparam logic [CMD_W-1:0] OP_GET_SAMP  = 8'h02;
  localparam logic [CMD_W-1:0] OP_GET_PHASE = 8'h08;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_RESP,
    ST_STREAM
  } rcif_state_e;
endpackage

// File: rtl/rcif_frontend.sv
module rcif_frontend (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic din,
  output logic rst_sync_n,
  output logic sclk_rise,
  output logic start_cond
);
  logic [1:0] rst_pipe;
  logic       sclk_q;
  logic       din_q;

  // reset asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sclk_q <= 1'b1;
      din_q  <= 1'b1;
    end else begin
      sclk_q <= sclk;
      din_q  <= din;
    end
  end

  assign sclk_rise  = sclk & ~sclk_q;
  assign start_cond = sclk & sclk_q & din & ~din_q;
endmodule

// File: rtl/rcif_regs.sv
module rcif_regs
  import rcif_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    page_we,
  input  logic [$clog2(PG_N)-1:0] page_idx,
  input  logic                    samp_we,
  input  logic                    nlen_we,
  input  logic [SAMP_W-1:0]       wr_val,
  output logic [CFG_W-1:0]        cfg,
  output logic [SAMP_W-1:0]       samp_q,
  output logic [NLEN_W-1:0]       nlen_q
);
  localparam logic [PG_W-1:0] PAGE0_RST = PG_W'(1) << (PG_W - 1);

  for (genvar p = 0; p < PG_N; p++) begin : g_page
    localparam logic [PG_W-1:0] RST_VAL = (p == 0) ? PAGE0_RST : '0;
    logic [PG_W-1:0] page_q;
    logic            hit;
    assign hit = page_we && (page_idx == p);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   page_q <= RST_VAL;
      else if (hit) page_q <= wr_val[PG_W-1:0];
    end
    assign cfg[p*PG_W +: PG_W] = page_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      nlen_q <= '0;
    end else begin
      if (samp_we) samp_q <= wr_val;
      if (nlen_we) nlen_q <= wr_val[NLEN_W-1:0];
    end
  end
endmodule

// File: rtl/rcif_seq.sv
module rcif_seq
  import rcif_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclk_rise,
  input  logic                    start_cond,
  input  logic                    din,
  input  logic [PH_W-1:0]         phase,
  input  logic                    amp_cmp,
  input  logic                    ant_fail,
  input  logic [CFG_W-1:0]        cfg,
  input  logic [SAMP_W-1:0]       samp_q,
  input  logic [NLEN_W-1:0]       nlen_q,
  output logic                    page_we,
  output logic [$clog2(PG_N)-1:0] page_idx,
  output logic                    samp_we,
  output logic                    nlen_we,
  output logic [SAMP_W-1:0]       wr_val,
  output logic                    dout_q,
  output logic                    rd_q,
  output logic                    wr_q
);
  rcif_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CMD_W-2:0]  sh_q, sh_d;
  logic [CMD_W-1:0]  sh_nx;
  logic [CMD_W-1:0]  resp_q, resp_d;
  logic [RCNT_W-1:0] rcnt_q, rcnt_d;
  logic              dout_d, rd_d, wr_d;
  logic [PG_W-1:0]   pg_rd;
  logic [PG_W-1:0]   pg_hi;

  assign sh_nx    = {sh_q, din};
  assign page_idx = sh_nx[PG_W+1:PG_W];
  assign wr_val   = sh_nx[SAMP_W-1:0];
  assign pg_rd    = cfg[int'(sh_nx[1:0])*PG_W +: PG_W];
  assign pg_hi    = sh_nx[1] ? {2'b00, amp_cmp, ant_fail} : nlen_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    resp_d  = resp_q;
    rcnt_d  = rcnt_q;
    dout_d  = dout_q;
    rd_d    = rd_q;
    wr_d    = wr_q;
    page_we = 1'b0;
    samp_we = 1'b0;
    nlen_we = 1'b0;
    if (start_cond && st_q != ST_STREAM) begin
      st_d   = ST_CMD;
      cnt_d  = '0;
      sh_d   = '0;
      rcnt_d = '0;
      dout_d = 1'b1;
    end else if (sclk_rise) begin
      case (st_q)
        ST_CMD: begin
          sh_d  = sh_nx[CMD_W-2:0];
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(SHORT_W - 1) && sh_nx[2:1] == 2'b11) begin
            st_d = ST_STREAM;
            rd_d = sh_nx[0];
            wr_d = ~sh_nx[0];
          end else if (cnt_q == CNT_W'(CMD_W - 1)) begin
            st_d = ST_IDLE;
            if (sh_nx[7:6] == 2'b01) begin
              page_we = 1'b1;
            end else if (sh_nx[7:6] == 2'b10) begin
              samp_we = 1'b1;
            end else if (sh_nx[7:4] == 4'b0001) begin
              nlen_we = 1'b1;
              wr_d    = 1'b1;
              st_d    = ST_STREAM;
            end else if (sh_nx == OP_GET_SAMP) begin
              resp_d = {2'b00, samp_q};
              st_d   = ST_RESP;
            end else if (sh_nx == OP_GET_PHASE) begin
              resp_d = {2'b00, phase};
              st_d   = ST_RESP;
            end else if (sh_nx[7:2] == 6'b000001) begin
              resp_d = {pg_hi, pg_rd};
              st_d   = ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (rcnt_q == RCNT_W'(CMD_W)) begin
            dout_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            dout_d = resp_q[CMD_W-1];
            resp_d = {resp_q[CMD_W-2:0], 1'b0};
            rcnt_d = rcnt_q + 1'b1;
          end
        end
        ST_STREAM: begin
          rd_d = 1'b0;
          wr_d = 1'b0;
          st_d = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      resp_q <= '0;
      rcnt_q <= '0;
      dout_q <= 1'b1;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      resp_q <= resp_d;
      rcnt_q <= rcnt_d;
      dout_q <= dout_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
    end
  end
endmodule

// File: rtl/rdr_cmd_if.sv
module rdr_cmd_if
  import rcif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              rx_data,
  input  logic [PH_W-1:0]   phase,
  input  logic              amp_cmp,
  input  logic              ant_fail,
  output logic              dout,
  output logic              read_mode,
  output logic              write_mode,
  output logic [CFG_W-1:0]  cfg,
  output logic [SAMP_W-1:0] samp_time,
  output logic [NLEN_W-1:0] pulse_len,
  output logic              power_idle,
  output logic              power_off
);
  logic                    rst_sync_n;
  logic                    sclk_rise;
  logic                    start_cond;
  logic                    page_we;
  logic                    samp_we;
  logic                    nlen_we;
  logic [$clog2(PG_N)-1:0] page_idx;
  logic [SAMP_W-1:0]       wr_val;
  logic                    dout_q;

  rcif_frontend u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .din        (din),
    .rst_sync_n (rst_sync_n),
    .sclk_rise  (sclk_rise),
    .start_cond (start_cond)
  );

  rcif_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .page_we  (page_we),
    .page_idx (page_idx),
    .samp_we  (samp_we),
    .nlen_we  (nlen_we),
    .wr_val   (wr_val),
    .cfg      (cfg),
    .samp_q   (samp_time),
    .nlen_q   (pulse_len)
  );

  rcif_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sclk_rise  (sclk_rise),
    .start_cond (start_cond),
    .din        (din),
    .phase      (phase),
    .amp_cmp    (amp_cmp),
    .ant_fail   (ant_fail),
    .cfg        (cfg),
    .samp_q     (samp_time),
    .nlen_q     (pulse_len),
    .page_we    (page_we),
    .page_idx   (page_idx),
    .samp_we    (samp_we),
    .nlen_we    (nlen_we),
    .wr_val     (wr_val),
    .dout_q     (dout_q),
    .rd_q       (read_mode),
    .wr_q       (write_mode)
  );

  assign dout       = read_mode ? rx_data : dout_q;
  assign power_idle = cfg[PG_W+2] & ~cfg[PG_W+3];
  assign power_off  = cfg[PG_W+2] &  cfg[PG_W+3];
endmodule

// File: rtl/rdr_cmd_if_chk.sv
module rdr_cmd_if_chk
  import rcif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              din,
  input logic              dout,
  input logic              read_mode,
  input logic              write_mode,
  input logic [CFG_W-1:0]  cfg,
  input logic [SAMP_W-1:0] samp_time,
  input logic              power_idle,
  input logic              power_off
);
  logic sclk_d1, sclk_d2, din_d1, din_d2, rd_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d1 <= 1'b1;
      sclk_d2 <= 1'b1;
      din_d1  <= 1'b1;
      din_d2  <= 1'b1;
      rd_d1   <= 1'b0;
    end else begin
      sclk_d1 <= sclk;
      sclk_d2 <= sclk_d1;
      din_d1  <= din;
      din_d2  <= din_d1;
      rd_d1   <= read_mode;
    end
  end

  // R8 R9
  modes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(read_mode && write_mode));

  // R11
  stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && (read_mode || write_mode)) |=> !(read_mode || write_mode));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sclk) |=> ($stable(cfg) && $stable(samp_time)));

  // R12
  pwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_idle |-> !power_off);

  // R7
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_mode && !rd_d1 && !(sclk_d1 && !sclk_d2) &&
     !(sclk_d1 && sclk_d2 && din_d1 && !din_d2)) |-> $stable(dout));
endmodule

bind rdr_cmd_if rdr_cmd_if_chk u_chk (.*);

// File: tb/rdr_cmd_if_bench.sv
module rdr_cmd_if_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk, din, rx_data, amp_cmp, ant_fail;
  logic [5:0]  phase;
  logic        dout, read_mode, write_mode, power_idle, power_off;
  logic [15:0] cfg;
  logic [5:0]  samp_time;
  logic [3:0]  pulse_len;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       collecting = 1'b0;
  logic [7:0] got;
  int         nbits = 0;

  always #2 clk = ~clk;

  rdr_cmd_if u_rdr_cmd_if (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .rx_data(rx_data),
    .phase(phase), .amp_cmp(amp_cmp), .ant_fail(ant_fail), .dout(dout),
    .read_mode(read_mode), .write_mode(write_mode), .cfg(cfg),
    .samp_time(samp_time), .pulse_len(pulse_len),
    .power_idle(power_idle), .power_off(power_off)
  );

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic bit_out(logic b);
    din = b; wcyc(2);
    sclk = 1'b1; wcyc(4);
    sclk = 1'b0; wcyc(2);
  endtask

  task automatic start_seq();
    din = 1'b0; wcyc(2);
    sclk = 1'b1; wcyc(3);
    din = 1'b1; wcyc(3);
    sclk = 1'b0; wcyc(2);
  endtask

  task automatic send_cmd(logic [7:0] c);
    start_seq();
    for (int i = 7; i >= 0; i--) bit_out(c[i]);
  endtask

  // driver side of the scoreboard: queue the expected byte, clock it out
  task automatic read_resp(logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    collecting = 1'b1;
    for (int i = 0; i < 8; i++) bit_out(1'b0);
    collecting = 1'b0;
    sclk = 1'b1; wcyc(3);
    chk("R7 dout released after 17th rise", 32'(dout), 32'd1);
    sclk = 1'b0; wcyc(2);
  endtask

  // monitor side of the scoreboard
  always @(posedge sclk) begin
    if (collecting) begin
      repeat (3) @(negedge clk);
      got = {got[6:0], dout};
      nbits++;
      if (nbits == 8) begin
        nbits = 0;
        chk($sformatf("R7 %s", tag_q.pop_front()), 32'(got), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic ok;
    rst_n = 1'b0; sclk = 1'b0; din = 1'b0; rx_data = 1'b0;
    phase = 6'h00; amp_cmp = 1'b0; ant_fail = 1'b0;
    wcyc(5); rst_n = 1'b1; wcyc(5);

    // R1 reset state
    chk("R1 cfg", 32'(cfg), 32'h0008);
    chk("R1 samp_time", 32'(samp_time), 0);
    chk("R1 pulse_len", 32'(pulse_len), 0);
    chk("R1 modes", 32'({read_mode, write_mode}), 0);
    chk("R1 dout", 32'(dout), 1);

    // R2 bits without a start condition are ignored
    for (int i = 7; i >= 0; i--) bit_out(logic'((8'h45 >> i) & 1));
    chk("R2 no start", 32'(cfg), 32'h0008);
    // R3 page 0 write
    send_cmd(8'h45);
    chk("R3 page0 write", 32'(cfg), 32'h0005);
    // R2 restart mid-command
    start_seq(); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    send_cmd(8'h73);
    chk("R2 restart samp", 32'(samp_time), 0);
    chk("R2 R3 page3 write", 32'(cfg), 32'h3005);

    // R4 sampling time
    send_cmd(8'hAD);
    chk("R4 samp write", 32'(samp_time), 32'h2D);
    send_cmd(8'h02);
    read_resp(8'h2D, "R4 samp read");

    // R5 phase
    phase = 6'h3A;
    send_cmd(8'h08);
    read_resp(8'h3A, "R5 phase read");

    // R10 long write form
    send_cmd(8'h1A);
    chk("R10 write_mode", 32'(write_mode), 1);
    chk("R10 pulse_len", 32'(pulse_len), 32'hA);
    sclk = 1'b1; wcyc(3);
    chk("R11 write end", 32'(write_mode), 0);
    sclk = 1'b0; wcyc(2);

    // R6 page readback
    send_cmd(8'h04); read_resp(8'hA5, "R6 page0");
    send_cmd(8'h05); read_resp(8'hA0, "R6 page1");
    amp_cmp = 1'b1; ant_fail = 1'b0;
    send_cmd(8'h07); read_resp(8'h23, "R6 page3");
    amp_cmp = 1'b0; ant_fail = 1'b1;
    send_cmd(8'h06); read_resp(8'h10, "R6 page2");

    // R8 read streaming
    start_seq(); bit_out(1'b1); bit_out(1'b1);
    din = 1'b1; wcyc(2); sclk = 1'b1; wcyc(3);
    chk("R8 read_mode", 32'(read_mode), 1);
    rx_data = 1'b0; wcyc(1);
    chk("R8 dout low", 32'(dout), 0);
    rx_data = 1'b1; wcyc(1);
    chk("R8 dout high", 32'(dout), 1);
    sclk = 1'b0; wcyc(2);
    rx_data = 1'b0;
    sclk = 1'b1; wcyc(3);
    chk("R11 read end", 32'(read_mode), 0);
    sclk = 1'b0; wcyc(2);
    for (int i = 0; i < 5; i++) bit_out(logic'(i % 2));
    chk("R8 tail ignored", 32'({cfg, samp_time}), 32'({16'h3005, 6'h2D}));
    chk("R8 dout idle", 32'(dout), 1);

    // R9 short write form, R11 start ignored while streaming
    start_seq(); bit_out(1'b1); bit_out(1'b1);
    din = 1'b0; wcyc(2); sclk = 1'b1; wcyc(3);
    chk("R9 write_mode", 32'(write_mode), 1);
    chk("R9 pulse_len kept", 32'(pulse_len), 32'hA);
    din = 1'b1; wcyc(3);
    chk("R11 start ignored", 32'(write_mode), 1);
    sclk = 1'b0; wcyc(2); din = 1'b0; wcyc(2);
    sclk = 1'b1; wcyc(3);
    chk("R11 short write end", 32'(write_mode), 0);
    sclk = 1'b0; wcyc(2);

    // R12 power selection
    send_cmd(8'h54);
    chk("R12 idle", 32'({power_idle, power_off}), 32'b10);
    send_cmd(8'h5C);
    chk("R12 off", 32'({power_idle, power_off}), 32'b01);
    send_cmd(8'h50);
    chk("R12 active", 32'({power_idle, power_off}), 32'b00);

    // R13 undefined codes
    send_cmd(8'h00);
    ok = 1'b1;
    for (int i = 0; i < 9; i++) begin
      din = 1'b0; wcyc(2); sclk = 1'b1; wcyc(3);
      if (dout !== 1'b1) ok = 1'b0;
      sclk = 1'b0; wcyc(2);
    end
    chk("R13 no response", 32'(ok), 1);
    send_cmd(8'h03);
    chk("R13 state kept", 32'({cfg, samp_time, pulse_len}), 32'({16'h3005, 6'h2D, 4'hA}));
    chk("R13 no mode", 32'({read_mode, write_mode}), 0);

    wcyc(5);
    summary();
    $finish;
  end
endmodule